// File: doc/BRIEF.md
# Output Compare PWM Timer

This block is a free-running timer with two output compare channels that together make a pulse-width modulated waveform on one pin. A prescaler divides the bus clock by a power of two to make the count tick. The period channel (channel 7) compares against the counter. On a match it can send the counter back to zero and force the pin to a preset level. The duty channel (channel 4) compares against the same counter and applies its own action to the pin.

Software configures the block through a small write-only register port. The compare values, the pin action, the force mask and level, the output-select bits and the control fields (counter-clear enable and prescale code) each have their own address.

A channel "match" happens on a count tick when the counter value equals that channel's compare value. The pin is registered. It takes its new level on the clock edge of the tick that matched.

Top module: `oc_pwm_timer`

## Requirements
- R1: Reset (rst_n low) clears every register and the counter, and holds pwm_o low. After reset, pwm_o stays low until software configures the block.
- R2: The prescale code in bits 2:0 of the control register (address 0) makes the counter advance once every 2^code bus clocks. Code 1 divides by 2 and code 2 divides by 4.
- R3: When bit 3 of the control register is 1, a channel 7 match returns the counter to 0 on the next tick. When the bit is 0, the counter keeps counting past the channel 7 value.
- R4: In the output-select register (address 1), bit n makes channel n an output compare channel. With bit 4 clear, pwm_o is held low and ignores every action. With bit 7 clear, channel 7 forces no level.
- R5: The channel 4 action field (address 2, bits 1:0) applies on a channel 4 match: 00 leaves the pin unchanged, 01 toggles it, 10 drives it low and 11 drives it high.
- R6: When output-select bits 4 and 7 are set and bit 4 of the channel 7 mask register (address 3) is set, a channel 7 match drives pwm_o to bit 4 of the channel 7 data register (address 4). With the mask bit clear, no level is forced.
- R7: When channel 7 and channel 4 match on the same tick and channel 7 forces a level, the forced level wins over the channel 4 action.
- R8: The pin holds its level between actions. A channel 4 compare value (address 6) above the channel 7 compare value (address 5) never matches while the counter clears on channel 7.
- R9: Take prescale 0, counter clear on, toggle action, mask bit set, C7 as the channel 7 compare value and C4 < C7 as the channel 4 compare value. Each period is C7+1 ticks. pwm_o is high for C7-C4 of those ticks with forced level 0, and for C4+1 ticks with forced level 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 output select, 2 action, 3 mask, 4 data, 5 channel 7 compare, 6 channel 4 compare |
| wr_data | input | CNT_W (16) | Register write data |
| pwm_o | output | 1 | Channel 4 pin |

## Verification
The channel 7 force and the channel 4 action can land on the same tick when both compare values are equal. The bench sets the two compare values to the same number and runs the test with each forced level. The pin must then sit constantly at the forced level. If the toggle won, the pin would be high for half of the window instead. The high time is counted over a window of exactly two periods, so the result does not depend on the phase at which the window starts.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_OSEL = 3'd1,
      RA_ACT  = 3'd2,
      RA_MASK = 3'd3,
      RA_DATA = 3'd4,
      RA_PER  = 3'd5,
      RA_DUTY = 3'd6
   } reg_addr_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } pin_act_e;

   localparam int CTRL_CLR_BIT = 3;
   localparam int ADDR_W       = 3;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
   import pwm_tmr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int NCH        = 8,
   parameter int PWM_CH     = 4,
   parameter int PER_CH     = 7,
   parameter int PSC_CODE_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [CNT_W-1:0]      wr_data,
   output logic                  clr_en_o,
   output logic [PSC_CODE_W-1:0] psc_code_o,
   output logic                  osel_pwm_o,
   output logic                  osel_per_o,
   output pin_act_e              act_o,
   output logic                  mask_pwm_o,
   output logic                  data_pwm_o,
   output logic [CNT_W-1:0]      cmp_per_o,
   output logic [CNT_W-1:0]      cmp_duty_o
);

   if (NCH > CNT_W) begin : g_chk_nch
      $error("pwm_tmr_regs: NCH must fit in the data width");
   end
   if (PSC_CODE_W > CTRL_CLR_BIT) begin : g_chk_psc
      $error("pwm_tmr_regs: prescale field overlaps the clear bit");
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clr_en_o   <= 1'b0;
         psc_code_o <= '0;
         osel_pwm_o <= 1'b0;
         osel_per_o <= 1'b0;
         act_o      <= ACT_NONE;
         mask_pwm_o <= 1'b0;
         data_pwm_o <= 1'b0;
         cmp_per_o  <= '0;
         cmp_duty_o <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(wr_addr))
            RA_CTRL: begin
               clr_en_o   <= wr_data[CTRL_CLR_BIT];
               psc_code_o <= wr_data[PSC_CODE_W-1:0];
            end
            RA_OSEL: begin
               osel_pwm_o <= wr_data[PWM_CH];
               osel_per_o <= wr_data[PER_CH];
            end
            RA_ACT:  act_o      <= pin_act_e'(wr_data[1:0]);
            RA_MASK: mask_pwm_o <= wr_data[PWM_CH];
            RA_DATA: data_pwm_o <= wr_data[PWM_CH];
            RA_PER:  cmp_per_o  <= wr_data;
            RA_DUTY: cmp_duty_o <= wr_data;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
   parameter int CODE_W = 3,
   parameter bit BYPASS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o
);

   localparam int DIV_W = (1 << CODE_W) - 1;

   if (CODE_W < 1 || CODE_W > 4) begin : g_chk_code
      $error("pwm_tmr_prescale: CODE_W out of range");
   end

   if (BYPASS) begin : g_bypass
      logic unused_code;
      assign unused_code = ^code_i;
      assign tick_o = 1'b1;
   end else begin : g_divide
      logic [DIV_W-1:0] pre_q;
      logic [DIV_W-1:0] sel_mask;

      always_comb begin
         for (int i = 0; i < DIV_W; i++) begin
            sel_mask[i] = (i < int'(code_i));
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) pre_q <= '0;
         else        pre_q <= pre_q + 1'b1;
      end

      assign tick_o = ((pre_q & sel_mask) == sel_mask);

      // R2: divide-by-two never yields two ticks in a row
      a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
         (code_i == 1 && tick_o) |=> (code_i != 1 || !tick_o));
   end

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             clr_en_i,
   input  logic [CNT_W-1:0] cmp_per_i,
   input  logic [CNT_W-1:0] cmp_duty_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_per_o,
   output logic             hit_duty_o
);

   localparam int NCMP = 2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_arr [NCMP];
   logic [NCMP-1:0]  hit;

   assign cmp_arr[0] = cmp_per_i;
   assign cmp_arr[1] = cmp_duty_i;

   for (genvar g = 0; g < NCMP; g++) begin : g_cmp
      assign hit[g] = tick_i && (cnt_q == cmp_arr[g]);
   end

   assign hit_per_o  = hit[0];
   assign hit_duty_o = hit[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (clr_en_i && hit[0]) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   // R3: period match with clear enabled returns the count to zero
   a_r3_clear_on_period: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && hit_per_o) |=> (cnt_o == '0));

   // R3: without a clearing match, every tick advances the count by one
   a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !(clr_en_i && hit_per_o)) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

   // R2: the count is frozen between ticks
   a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_o));

endmodule

// File: rtl/pwm_tmr_pin.sv
module pwm_tmr_pin
   import pwm_tmr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     hit_per_i,
   input  logic     hit_duty_i,
   input  logic     osel_pwm_i,
   input  logic     osel_per_i,
   input  pin_act_e act_i,
   input  logic     mask_pwm_i,
   input  logic     data_pwm_i,
   output logic     pin_o
);

   logic pin_q;
   logic pin_d;
   logic force_en;
   logic act_en;

   assign force_en = hit_per_i && osel_per_i && mask_pwm_i;
   assign act_en   = hit_duty_i;

   always_comb begin
      pin_d = pin_q;
      if (!osel_pwm_i) begin
         pin_d = 1'b0;
      end else if (force_en) begin
         pin_d = data_pwm_i;
      end else if (act_en) begin
         case (act_i)
            ACT_TOGGLE: pin_d = ~pin_q;
            ACT_LOW:    pin_d = 1'b0;
            ACT_HIGH:   pin_d = 1'b1;
            default:    pin_d = pin_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_d;
   end

   assign pin_o = pin_q;

   // R6, R7: a forcing period match lands the data level, whatever channel 4 does
   a_r6_force_level: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_per_i && osel_per_i && osel_pwm_i && mask_pwm_i) |=> (pin_o == $past(data_pwm_i)));

   // R5: a lone duty match with the toggle action flips the pin
   a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_duty_i && !hit_per_i && osel_pwm_i && act_i == ACT_TOGGLE) |=> (pin_o != $past(pin_o)));

   // R8: no match, no change
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_per_i && !hit_duty_i && osel_pwm_i) |=> $stable(pin_o));

   // R4: deselected channel keeps the pin low
   a_r4_deselect_low: assert property (@(posedge clk) disable iff (!rst_n)
      !osel_pwm_i |=> !pin_o);

endmodule

// File: rtl/oc_pwm_timer.sv
module oc_pwm_timer
   import pwm_tmr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int NCH        = 8,
   parameter int PWM_CH     = 4,
   parameter int PER_CH     = 7,
   parameter int PSC_CODE_W = 3,
   parameter bit PSC_BYPASS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              pwm_o
);

   if (CNT_W < 4) begin : g_chk_w
      $error("oc_pwm_timer: CNT_W too small");
   end
   if (PWM_CH >= NCH || PER_CH >= NCH || PWM_CH == PER_CH) begin : g_chk_ch
      $error("oc_pwm_timer: channel indices invalid");
   end

   logic                  clr_en;
   logic [PSC_CODE_W-1:0] psc_code;
   logic                  osel_pwm;
   logic                  osel_per;
   pin_act_e              act;
   logic                  mask_pwm;
   logic                  data_pwm;
   logic [CNT_W-1:0]      cmp_per;
   logic [CNT_W-1:0]      cmp_duty;
   logic                  tick;
   logic [CNT_W-1:0]      cnt;
   logic                  hit_per;
   logic                  hit_duty;

   pwm_tmr_regs #(
      .CNT_W(CNT_W), .NCH(NCH), .PWM_CH(PWM_CH), .PER_CH(PER_CH), .PSC_CODE_W(PSC_CODE_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .clr_en_o(clr_en), .psc_code_o(psc_code), .osel_pwm_o(osel_pwm), .osel_per_o(osel_per),
      .act_o(act), .mask_pwm_o(mask_pwm), .data_pwm_o(data_pwm),
      .cmp_per_o(cmp_per), .cmp_duty_o(cmp_duty)
   );

   pwm_tmr_prescale #(.CODE_W(PSC_CODE_W), .BYPASS(PSC_BYPASS)) i_psc (
      .clk(clk), .rst_n(rst_n), .code_i(psc_code), .tick_o(tick)
   );

   pwm_tmr_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_en_i(clr_en),
      .cmp_per_i(cmp_per), .cmp_duty_i(cmp_duty),
      .cnt_o(cnt), .hit_per_o(hit_per), .hit_duty_o(hit_duty)
   );

   pwm_tmr_pin i_pin (
      .clk(clk), .rst_n(rst_n), .hit_per_i(hit_per), .hit_duty_i(hit_duty),
      .osel_pwm_i(osel_pwm), .osel_per_i(osel_per), .act_i(act),
      .mask_pwm_i(mask_pwm), .data_pwm_i(data_pwm), .pin_o(pwm_o)
   );

   // R3: with clearing on, the count never passes the period value once below it
   a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && $past(clr_en) && $past(cnt) <= $past(cmp_per) && $stable(cmp_per))
         |-> (cnt <= cmp_per));

endmodule

// File: tb/test_oc_pwm_timer.sv
`timescale 1ns/1ps
module test_oc_pwm_timer;

   localparam int CW = 16;

   typedef struct packed {
      logic [2:0]  psc;
      logic        clr;
      logic [7:0]  osel;
      logic [1:0]  act;
      logic [7:0]  mask;
      logic [7:0]  data;
      logic [15:0] c7;
      logic [15:0] c4;
      int          exp_high;
      int          req;
   } vec_t;

   localparam int NV = 19;
   // expected = high cycles over a window of two periods
   localparam vec_t VEC [NV] = '{
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h00, 16'd200, 16'd20,  360, 9}, // R9 level 0
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h10, 16'd200, 16'd180, 362, 9}, // R9 level 1
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h00, 16'd50,  16'd10,  80,  9}, // R9
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h10, 16'd50,  16'd10,  22,  6}, // R6
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h00, 16'd30,  16'd29,  2,   9}, // R9 edge
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h10, 16'd30,  16'd0,   2,   9}, // R9 edge
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h10, 16'd40,  16'd100, 82,  8}, // R8 no duty match
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h00, 8'h00, 16'd40,  16'd10,  41,  6}, // R6 mask clear
      '{3'd0, 1'b1, 8'h10, 2'd1, 8'h10, 8'h10, 16'd40,  16'd10,  41,  4}, // R4 ch7 not output
      '{3'd0, 1'b1, 8'h80, 2'd1, 8'h10, 8'h10, 16'd40,  16'd10,  0,   4}, // R4 ch4 not output
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h10, 16'd40,  16'd40,  82,  7}, // R7 level 1
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h00, 16'd40,  16'd40,  0,   7}, // R7 level 0
      '{3'd0, 1'b1, 8'h90, 2'd2, 8'h10, 8'h10, 16'd40,  16'd10,  22,  5}, // R5 drive low
      '{3'd0, 1'b1, 8'h90, 2'd3, 8'h10, 8'h00, 16'd40,  16'd10,  60,  5}, // R5 drive high
      '{3'd0, 1'b1, 8'h90, 2'd0, 8'h10, 8'h10, 16'd40,  16'd10,  82,  5}, // R5 no action
      '{3'd1, 1'b1, 8'h90, 2'd1, 8'h10, 8'h00, 16'd40,  16'd10,  120, 2}, // R2 divide by 2
      '{3'd2, 1'b1, 8'h90, 2'd1, 8'h10, 8'h00, 16'd40,  16'd10,  240, 2}, // R2 divide by 4
      '{3'd0, 1'b0, 8'h90, 2'd1, 8'h10, 8'h10, 16'd20,  16'd30,  0,   3}, // R3 free run
      '{3'd0, 1'b1, 8'h90, 2'd1, 8'h10, 8'h10, 16'd20,  16'd30,  42,  3}  // R3 clear on
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          pwm_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   oc_pwm_timer #(.CNT_W(CW)) i_oc_pwm_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_o(pwm_o)
   );

   task automatic check(input string tag, input int actual, input int expected);
      n_chk++;
      if (actual != expected) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_o) h++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int h;
      int per;
      repeat (3) @(negedge clk);
      check("R1 pin during reset", int'(pwm_o), 0);
      rst_n = 1'b1;
      count_high(60, h);
      check("R1 pin low after reset", h, 0);

      for (int v = 0; v < NV; v++) begin
         do_reset();
         wr(3'd5, VEC[v].c7);
         wr(3'd6, VEC[v].c4);
         wr(3'd1, {8'h00, VEC[v].osel});
         wr(3'd2, {14'd0, VEC[v].act});
         wr(3'd3, {8'h00, VEC[v].mask});
         wr(3'd4, {8'h00, VEC[v].data});
         wr(3'd0, {12'd0, VEC[v].clr, VEC[v].psc});
         per = (int'(VEC[v].c7) + 1) << VEC[v].psc;
         repeat (2 * per + 60) @(negedge clk);
         count_high(2 * per, h);
         check($sformatf("R%0d vector %0d", VEC[v].req, v), h, VEC[v].exp_high);
      end

      // R8: toggling disabled and nothing forced, the pin holds its level
      do_reset();
      wr(3'd5, 16'd30);
      wr(3'd6, 16'd5);
      wr(3'd1, 16'h0090);
      wr(3'd2, 16'd0);
      wr(3'd0, 16'h0008);
      count_high(200, h);
      check("R8 hold low", h, 0);

      // R1: reset mid-run clears the configuration and the pin
      do_reset();
      wr(3'd5, 16'd40);
      wr(3'd1, 16'h0090);
      wr(3'd3, 16'h0010);
      wr(3'd4, 16'h0010);
      wr(3'd0, 16'h0008);
      repeat (100) @(negedge clk);
      check("R6 forced high before reset", int'(pwm_o), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 pin low in reset", int'(pwm_o), 0);
      rst_n = 1'b1;
      count_high(150, h);
      check("R1 registers cleared", h, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule